// File: doc/BRIEF.md
# Program-Counter Region Event Profiler

This block observes a running processor from the outside and measures where that processor spends its time. Each clock cycle it compares the live program counter against a set of address windows that software can reprogram. For every window that contains the current program counter, it adds one to a cycle counter. It also adds one to each of four cache-event counters whose strobe is high in that cycle: read hit, read miss, write hit and write miss. One more set of counters keeps machine-wide totals that do not depend on the program counter.

The monitored program needs no extra instructions and never stalls. All matching and counting run in parallel logic at the full clock rate. A small register port loads the window bounds. A second indexed port returns any counter one cycle after it is asked for. A global enable turns counting on and off, and a clear input zeroes every counter at once.

Top module: `pc_region_profiler`

## Requirements
- R1: After reset every counter reads zero, every window bound is zero (so no window matches), and `rd_valid` is low.
- R2: A write with `wr_en` high sets one window bound. `wr_addr[0]` selects the bound: 0 is the lower bound and 1 is the upper bound. The bits above it hold the window index. A window matches when lower <= pc < upper, so a window whose lower bound is not below its upper bound matches nothing.
- R3: Each enabled cycle adds one to the cycle counter of every window that matches the program counter. Overlapping windows are all credited in the same cycle.
- R4: Event strobes are mapped as `ev[0]` read hit, `ev[1]` read miss, `ev[2]` write hit and `ev[3]` write miss. In an enabled cycle, each event counter of a matching window rises by one for each strobe bit that is high.
- R5: The totals slot (index NREG) counts every enabled cycle and every strobe, whatever the program counter.
- R6: While `cnt_en` is low, no counter changes, whatever the program counter and the strobes are.
- R7: When `clr` is high, every counter is zero after the next edge. This holds even if an increment is due in the same cycle. The window bounds are kept.
- R8: Counters saturate at their all-ones value and never wrap.
- R9: A read request captures the counter chosen by `rd_addr` = {slot, kind}. Slot 0..NREG-1 is a window and slot NREG is the totals. Kind is 3 bits: 0 cycles, 1 read hit, 2 read miss, 3 write hit, 4 write miss. The counter value from the request edge appears on `rd_data`, zero-extended, with `rd_valid` high in the next cycle. Any other slot or kind returns zero. `rd_valid` is low in cycles after no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | PCW | Current program counter of the monitored processor |
| ev | input | 4 | Single-cycle cache event strobes (see R4) |
| cnt_en | input | 1 | Global count enable |
| clr | input | 1 | Zero all counters |
| wr_en | input | 1 | Bound write strobe |
| wr_addr | input | log2(NREG)+1 | {window index, upper/lower select} |
| wr_data | input | PCW | Bound value |
| rd_req | input | 1 | Counter read request |
| rd_addr | input | log2(NREG+1)+3 | {slot, kind} |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | CYCW | Counter value, zero-extended |

## Verification
The assertions take the control inputs (`cnt_en`, `clr`, `rd_req`) to be known levels at every rising edge after reset. They also take the totals slot to be the reference that no window cycle count can exceed, which is true only if window and totals counters are cleared and enabled together. The bench drives every input at the falling edge and never leaves one undriven. Random program counters fall in a small range that covers the programmed windows, their exact boundaries and empty or inverted windows. Clear pulses are rare enough that counters also reach saturation.

// File: rtl/prof_pkg.sv
package prof_pkg;
  localparam int NEV   = 4;
  localparam int KINDW = 3;
  // counter kind field of the read address
  localparam logic [KINDW-1:0] KIND_CYC = 3'd0;
  // event kind = strobe bit index + 1
  localparam int EV_RDHIT  = 0;
  localparam int EV_RDMISS = 1;
  localparam int EV_WRHIT  = 2;
  localparam int EV_WRMISS = 3;
endpackage

// File: rtl/prof_range_match.sv
module prof_range_match #(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lo_we,
  input  logic           hi_we,
  input  logic [PCW-1:0] wr_data,
  input  logic [PCW-1:0] pc,
  output logic           hit
);
  logic [PCW-1:0] lo_q, hi_q, lo_d, hi_d;

  always_comb begin
    lo_d = lo_we ? wr_data : lo_q;
    hi_d = hi_we ? wr_data : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // inclusive lower, exclusive upper
  assign hit = (pc >= lo_q) && (pc < hi_q);
endmodule

// File: rtl/prof_sat_counter.sv
module prof_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                     cnt_d = '0;
    else if (inc && cnt != MAXV) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/prof_readmux.sv
module prof_readmux import prof_pkg::*; #(
  parameter int NSLOT = 9,
  parameter int CYCW  = 48,
  parameter int EVW   = 32,
  localparam int SLOTW = $clog2(NSLOT),
  localparam int RAW   = SLOTW + KINDW
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_req,
  input  logic [RAW-1:0]                   rd_addr,
  input  logic [NSLOT-1:0][CYCW-1:0]       cyc_all,
  input  logic [NSLOT-1:0][NEV-1:0][EVW-1:0] ev_all,
  output logic                             rd_valid,
  output logic [CYCW-1:0]                  rd_data
);
  logic [SLOTW-1:0] slot;
  logic [KINDW-1:0] kind;
  logic [CYCW-1:0]  pick, data_d;

  assign slot = rd_addr[RAW-1:KINDW];
  assign kind = rd_addr[KINDW-1:0];

  always_comb begin
    pick = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot == SLOTW'(s)) begin
        if (kind == KIND_CYC) pick = cyc_all[s];
        for (int e = 0; e < NEV; e++)
          if (kind == KINDW'(e + 1)) pick = CYCW'(ev_all[s][e]);
      end
    end
    data_d = rd_req ? pick : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= data_d;
    end
  end
endmodule

// File: rtl/pc_region_profiler.sv
module pc_region_profiler import prof_pkg::*; #(
  parameter int NREG = 8,
  parameter int PCW  = 32,
  parameter int CYCW = 48,
  parameter int EVW  = 32,
  localparam int NSLOT = NREG + 1,
  localparam int RIDW  = $clog2(NREG),
  localparam int WAW   = RIDW + 1,
  localparam int SLOTW = $clog2(NSLOT),
  localparam int RAW   = SLOTW + KINDW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PCW-1:0]  pc,
  input  logic [NEV-1:0]  ev,
  input  logic            cnt_en,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [WAW-1:0]  wr_addr,
  input  logic [PCW-1:0]  wr_data,
  input  logic            rd_req,
  input  logic [RAW-1:0]  rd_addr,
  output logic            rd_valid,
  output logic [CYCW-1:0] rd_data
);
  logic [NSLOT-1:0]                   slot_hit;
  logic [NSLOT-1:0][CYCW-1:0]         cyc_pk;
  logic [NSLOT-1:0][NEV-1:0][EVW-1:0] ev_pk;

  // window comparators
  for (genvar r = 0; r < NREG; r++) begin : g_win
    logic lo_we, hi_we;
    assign lo_we = wr_en && (wr_addr[WAW-1:1] == RIDW'(r)) && !wr_addr[0];
    assign hi_we = wr_en && (wr_addr[WAW-1:1] == RIDW'(r)) &&  wr_addr[0];
    prof_range_match #(.PCW(PCW)) u_rng (
      .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we),
      .wr_data(wr_data), .pc(pc), .hit(slot_hit[r])
    );
  end
  // totals slot always matches
  assign slot_hit[NREG] = 1'b1;

  // counter banks
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic cyc_inc;
    assign cyc_inc = cnt_en && slot_hit[s];
    prof_sat_counter #(.W(CYCW)) u_cyc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(cyc_inc), .cnt(cyc_pk[s])
    );
    for (genvar e = 0; e < NEV; e++) begin : g_ev
      logic ev_inc;
      assign ev_inc = cnt_en && slot_hit[s] && ev[e];
      prof_sat_counter #(.W(EVW)) u_evc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(ev_inc), .cnt(ev_pk[s][e])
      );
    end
  end

  prof_readmux #(.NSLOT(NSLOT), .CYCW(CYCW), .EVW(EVW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .cyc_all(cyc_pk), .ev_all(ev_pk), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/prof_checker.sv
module prof_checker #(
  parameter int NSLOT = 9,
  parameter int CYCW  = 48
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cnt_en,
  input logic                       clr,
  input logic                       rd_req,
  input logic                       rd_valid,
  input logic [NSLOT-1:0][CYCW-1:0] cyc_all
);
  localparam int TOT = NSLOT - 1;
  localparam logic [CYCW-1:0] MAXV = '1;

  p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cyc_all == '0));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cyc_all));
  p_total_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr && cyc_all[TOT] != MAXV) |=> cyc_all[TOT] == $past(cyc_all[TOT]) + 1'b1);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cyc_all[TOT] == MAXV) |=> cyc_all[TOT] == MAXV);

  for (genvar s = 0; s < TOT; s++) begin : g_win
    p_window_le_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_all[s] <= cyc_all[TOT]);
  end
endmodule

bind pc_region_profiler prof_checker #(.NSLOT(NSLOT), .CYCW(CYCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr(clr),
  .rd_req(rd_req), .rd_valid(rd_valid), .cyc_all(cyc_pk)
);

// File: tb/sim_pc_region_profiler.sv
module sim_pc_region_profiler;
  localparam int NREG = 8, PCW = 16, CYCW = 10, EVW = 6;
  localparam int NSLOT = NREG + 1;
  localparam int unsigned CMAX = (1 << CYCW) - 1;
  localparam int unsigned EMAX = (1 << EVW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PCW-1:0] pc = '0, wr_data = '0;
  logic [3:0] ev = '0;
  logic cnt_en = 1'b0, clr = 1'b0, wr_en = 1'b0, rd_req = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [6:0] rd_addr = '0;
  logic rd_valid;
  logic [CYCW-1:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;

  int unsigned m_cyc [NSLOT];
  int unsigned m_ev  [NSLOT][4];
  logic [PCW-1:0] m_lo [NREG];
  logic [PCW-1:0] m_hi [NREG];

  always #4 clk = ~clk;

  pc_region_profiler #(.NREG(NREG), .PCW(PCW), .CYCW(CYCW), .EVW(EVW)) u0 (
    .clk(clk), .rst_n(rst_n), .pc(pc), .ev(ev), .cnt_en(cnt_en), .clr(clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic bit in_slot(int s, logic [PCW-1:0] p);
    if (s == NREG) return 1'b1;
    return (m_lo[s] <= p) && (p < m_hi[s]);
  endfunction

  function automatic int unsigned expect_of(int s, int k);
    if (s >= NSLOT) return 0;
    if (k == 0) return m_cyc[s];
    if (k <= 4) return m_ev[s][k-1];
    return 0;
  endfunction

  task automatic check(bit ok, string req, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic [PCW-1:0] p, logic [3:0] e, logic en, logic c);
    pc = p; ev = e; cnt_en = en; clr = c;
    @(posedge clk);
    for (int s = 0; s < NSLOT; s++) begin
      if (c) begin
        m_cyc[s] = 0;
        for (int k = 0; k < 4; k++) m_ev[s][k] = 0;
      end else if (en && in_slot(s, p)) begin
        if (m_cyc[s] != CMAX) m_cyc[s]++;
        for (int k = 0; k < 4; k++)
          if (e[k] && m_ev[s][k] != EMAX) m_ev[s][k]++;
      end
    end
    @(negedge clk);
    cnt_en = 1'b0; clr = 1'b0; ev = '0;
  endtask

  task automatic wbound(int r, logic [PCW-1:0] lo, logic [PCW-1:0] hi);
    wr_en = 1'b1; wr_addr = {3'(r), 1'b0}; wr_data = lo;
    @(posedge clk); m_lo[r] = lo; @(negedge clk);
    wr_addr = {3'(r), 1'b1}; wr_data = hi;
    @(posedge clk); m_hi[r] = hi; @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(int s, int k, string req);
    int unsigned exp;
    exp = expect_of(s, k);
    rd_req = 1'b1; rd_addr = {4'(s), 3'(k)};
    @(posedge clk); @(negedge clk);
    rd_req = 1'b0;
    check(rd_valid === 1'b1, {req, " valid"}, 32'(rd_valid), 1);
    check(rd_data === CYCW'(exp), req, 32'(rd_data), exp);
  endtask

  task automatic check_all(string req);
    for (int s = 0; s < NSLOT; s++)
      for (int k = 0; k < 5; k++) rd_check(s, k, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5A5A));
    for (int s = 0; s < NSLOT; s++) begin
      m_cyc[s] = 0;
      for (int k = 0; k < 4; k++) m_ev[s][k] = 0;
    end
    for (int r = 0; r < NREG; r++) begin m_lo[r] = '0; m_hi[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(rd_valid === 1'b0, "R1 rd_valid low", 32'(rd_valid), 0);
    check_all("R1 reset zero");
    // R1: zero bounds match nothing (only totals move)
    step(16'h0000, 4'hF, 1'b1, 1'b0);
    check_all("R1 zero bounds");

    // R2 windows: overlap, empty, inverted
    wbound(0, 16'h0010, 16'h0020);
    wbound(1, 16'h0018, 16'h0030);
    wbound(2, 16'h0040, 16'h0040);
    wbound(3, 16'h0050, 16'h0048);

    // R2/R3/R4 directed boundaries
    step(16'h0010, 4'b0001, 1'b1, 1'b0);
    step(16'h001F, 4'b0110, 1'b1, 1'b0);
    step(16'h0020, 4'b1000, 1'b1, 1'b0);
    step(16'h000F, 4'b1111, 1'b1, 1'b0);
    step(16'h0040, 4'b0011, 1'b1, 1'b0);
    step(16'h004C, 4'b1100, 1'b1, 1'b0);
    step(16'h0018, 4'b1010, 1'b1, 1'b0);
    check_all("R2 R3 R4 R5 windows");

    // R6: disabled cycles change nothing
    for (int i = 0; i < 5; i++) step(16'h0018, 4'hF, 1'b0, 1'b0);
    check_all("R6 enable low");

    // R7: clear beats increment, bounds kept
    step(16'h0018, 4'hF, 1'b1, 1'b1);
    check_all("R7 clear");
    step(16'h0019, 4'b0101, 1'b1, 1'b0);
    check_all("R7 bounds kept");

    // R9: invalid kind and slot read zero
    rd_check(0, 5, "R9 bad kind");
    rd_check(0, 7, "R9 bad kind");
    rd_check(9, 0, "R9 bad slot");
    rd_check(15, 1, "R9 bad slot");
    @(negedge clk);
    check(rd_valid === 1'b0, "R9 idle valid", 32'(rd_valid), 0);

    // random phase
    for (int r = 4; r < NREG; r++) begin
      logic [PCW-1:0] a, b;
      a = PCW'($urandom_range(0, 255));
      b = PCW'($urandom_range(0, 255));
      wbound(r, a, b);
    end
    for (int i = 0; i < 2000; i++) begin
      step(PCW'($urandom_range(0, 255)), 4'($urandom),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 299) == 0));
      if (i % 500 == 499) check_all("R3 R4 R5 random");
    end

    // R8: saturation
    step(16'h0010, 4'h0, 1'b0, 1'b1);
    for (int i = 0; i < 1100; i++) step(16'h0012, 4'hF, 1'b1, 1'b0);
    check_all("R8 saturate");
    step(16'h0012, 4'hF, 1'b1, 1'b1);
    check_all("R8 R7 clear saturated");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule